// File: doc/BRIEF.md
# Serial Three-Bit Window Matcher

The block takes one serial bit on every clock and keeps the last three bits it has seen as its state. Each new bit joins the two bits before it to form a fresh three-bit window. Windows therefore overlap: after a match, the next bit is tested together with the two newest bits of the matched window, and there is no restart.

A `match_o` flag rises when the window equals a target pattern fixed by a parameter. A second parameter selects when the flag appears. In registered-state (Moore) timing, the flag shows whether the stored window equals the target. In transition (Mealy) timing, the flag is decoded from the two newest stored bits plus the bit on the input in the same cycle. It is therefore high during the cycle whose incoming bit completes the pattern.

A small fill counter holds the flag low until enough bits have arrived after reset. This stops the cleared history from producing a false match.

Top module: `win_pattern_chk`

## Requirements
- R1: While `rst_ni` is low, `match_o` is 0, and the history and fill count are held at zero.
- R2: One bit of `bit_i` is consumed on each rising clock edge. It enters as the least significant history bit, and the oldest bit is dropped. The target is compared with bit 2 as the oldest bit and bit 0 as the newest.
- R3: Windows overlap. With the target 000, a run of four zeros gives a match on both the third and the fourth bit.
- R4: Moore timing: `match_o` is 1 in the cycle after the edge that stores a window equal to the target. It is 0 whenever the stored window differs from the target.
- R5: Mealy timing: `match_o` is 1 in the same cycle as the incoming bit that completes the target, before that bit is stored. It is 0 on every other input.
- R6: In Moore timing, `match_o` stays 0 until three bits have been stored after reset. In Mealy timing, it stays 0 until two bits have been stored.
- R7: The fill count saturates. A window that keeps matching keeps `match_o` at 1 for any number of cycles.
- R8: A reset in the middle of a stream discards the history. Matching restarts only after three new bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data, one bit per cycle |
| match_o | output | 1 | Window equals target |

## Verification
The main stream mixes the target 110 with near misses: 011, its mirror image, shows whether the bits enter in the right order. Runs of 1s and 0s place windows next to a match that must not fire. Back-to-back 110s show that matching continues after a hit.

Three copies run on the same stream: Moore timing with target 110, Mealy timing with target 110, and Moore timing with target 000. Comparing the first two shows the one-cycle lead of Mealy timing. The copy with target 000 is the only one that can show a false match from the cleared history, and it also shows overlapping matches. A long run of zeros and a reset in mid-stream test saturation and restart.

// File: rtl/win_pattern_pkg.sv
package win_pattern_pkg;
  typedef enum logic {
    TIMING_MOORE = 1'b0,
    TIMING_MEALY = 1'b1
  } timing_e;
endpackage

// File: rtl/win_hist.sv
module win_hist #(
  parameter int unsigned WIN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [WIN_W-1:0] hist_o
);
  logic [WIN_W-1:0] hist_q;

  // oldest bit falls off the top, new bit enters at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[WIN_W-2:0], bit_i};
  end

  assign hist_o = hist_q;

  p_hist_age_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hist_q[1] == $past(hist_q[0]));
endmodule

// File: rtl/win_fill.sv
module win_fill #(
  parameter int unsigned WIN_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic full_o,
  output logic near_o
);
  localparam int unsigned CW = $clog2(WIN_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WIN_W);
  localparam logic [CW-1:0] NEAR = CW'(WIN_W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == FULL);
  assign near_o = (cnt_q >= NEAR);

  p_fill_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);
  p_fill_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> near_o);
endmodule

// File: rtl/win_match.sv
module win_match
  import win_pattern_pkg::*;
#(
  parameter int unsigned      WIN_W  = 3,
  parameter logic [WIN_W-1:0] TARGET = 3'b110,
  parameter timing_e          TIMING = TIMING_MOORE
) (
  input  logic [WIN_W-1:0] hist_i,
  input  logic             bit_i,
  input  logic             full_i,
  input  logic             near_i,
  output logic             match_o
);
  generate
    if (TIMING == TIMING_MEALY) begin : g_mealy
      logic unused_mealy;
      assign unused_mealy = full_i ^ hist_i[WIN_W-1];
      assign match_o = near_i && ({hist_i[WIN_W-2:0], bit_i} == TARGET);
    end else begin : g_moore
      logic unused_moore;
      assign unused_moore = bit_i ^ near_i;
      assign match_o = full_i && (hist_i == TARGET);
    end
  endgenerate
endmodule

// File: rtl/win_pattern_chk.sv
module win_pattern_chk
  import win_pattern_pkg::*;
#(
  parameter int unsigned      WIN_W  = 3,
  parameter logic [WIN_W-1:0] TARGET = 3'b110,
  parameter timing_e          TIMING = TIMING_MOORE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic match_o
);
  logic [WIN_W-1:0] hist;
  logic             full;
  logic             near;

  win_hist #(.WIN_W(WIN_W)) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .hist_o(hist)
  );

  win_fill #(.WIN_W(WIN_W)) u_fill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .full_o(full),
    .near_o(near)
  );

  win_match #(.WIN_W(WIN_W), .TARGET(TARGET), .TIMING(TIMING)) u_match (
    .hist_i (hist),
    .bit_i  (bit_i),
    .full_i (full),
    .near_i (near),
    .match_o(match_o)
  );

  logic [WIN_W-1:0] win_next;
  assign win_next = {hist[WIN_W-2:0], bit_i};

  generate
    if (TIMING == TIMING_MEALY) begin : g_chk_mealy
      p_mealy_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> hist == TARGET);
      p_mealy_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> near);
    end else begin : g_chk_moore
      p_moore_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (near && win_next == TARGET) |=> match_o);
      p_moore_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> hist == TARGET);
      p_moore_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> full);
    end
  endgenerate
endmodule

// File: tb/win_pattern_chk_bench.sv
`timescale 1ns/1ps
module win_pattern_chk_bench;
  import win_pattern_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic m_moore, m_mealy, m_zero;
  int   checks = 0;
  int   errors = 0;
  logic [2:0] hist_m = 3'b000;
  int   cnt_m = 0;

  always #2.5 clk_i = ~clk_i;

  win_pattern_chk #(.WIN_W(3), .TARGET(3'b110), .TIMING(TIMING_MOORE)) u_win_pattern_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_moore));
  win_pattern_chk #(.WIN_W(3), .TARGET(3'b110), .TIMING(TIMING_MEALY)) u_win_pattern_chk_mealy (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_mealy));
  win_pattern_chk #(.WIN_W(3), .TARGET(3'b000), .TIMING(TIMING_MOORE)) u_win_pattern_chk_zero (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_zero));

  // {bit, expected Moore flag for target 110}
  localparam int NV = 17;
  localparam logic [1:0] VEC [NV] = '{
    2'b10, 2'b10, 2'b01, 2'b10, 2'b10, 2'b01, 2'b00, 2'b10, 2'b10,
    2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b01};

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // tbl[1]: use tbl[0] as Moore-110 expectation
  task automatic step(input logic b, input logic [1:0] tbl, input string req);
    logic e_mealy, e_moore, e_zero;
    @(negedge clk_i);
    bit_i = b;
    #1;
    e_mealy = (cnt_m >= 2) && ({hist_m[1:0], b} == 3'b110);
    chk(m_mealy, e_mealy, {req, " R5 mealy"});
    hist_m = {hist_m[1:0], b};
    if (cnt_m < 3) cnt_m++;
    @(posedge clk_i);
    #1;
    e_moore = (cnt_m == 3) && (hist_m == 3'b110);
    e_zero  = (cnt_m == 3) && (hist_m == 3'b000);
    chk(m_moore, tbl[1] ? tbl[0] : e_moore, {req, " R4 moore"});
    chk(m_zero, e_zero, {req, " R6 zero-target"});
  endtask

  task automatic do_reset(input string req);
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_i  = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk(m_moore, 1'b0, {req, " moore"});
    chk(m_mealy, 1'b0, {req, " mealy"});
    chk(m_zero, 1'b0, {req, " zero"});
    hist_m = 3'b000;
    cnt_m  = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1;
    chk(m_moore, 1'b0, "R1 time-zero");
    do_reset("R1");
    // R2 R3: mixed stream with near misses and back-to-back hits
    for (int i = 0; i < NV; i++) step(VEC[i][1], {1'b1, VEC[i][0]}, "R2 R3 table");
    // R6: cleared history must not match target 000 early; R3 overlap
    do_reset("R1 R8");
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, "R6 R3 zeros");
    // R7: long run keeps the zero target matching
    for (int i = 0; i < 200; i++) step(1'b0, 2'b00, "R7 saturate");
    // R8: reset mid-stream, then restart needs three fresh bits
    step(1'b1, 2'b00, "R8 pre");
    step(1'b1, 2'b00, "R8 pre");
    do_reset("R8 reset");
    step(1'b0, 2'b00, "R8 refill");
    step(1'b1, 2'b00, "R8 refill");
    step(1'b1, 2'b00, "R8 refill");
    step(1'b0, 2'b11, "R8 refill hit");
    step(1'b1, 2'b10, "R4 after hit");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule